// File: doc/BRIEF.md
# Interrupt Request Flag Register

This block collects interrupt requests from six external request pins and one internal timer source into a single 8-bit status register. Software reads and writes it through a simple strobe-based port. Each pin is first passed through an optional polarity inverter and then through a multi-flop synchronizer. After that, the pin is handled in one of two ways, chosen per pin by a configuration input:

- In edge-detection mode, a rising edge of the synchronized signal sets a sticky flag.
- In level-detection mode, the flag simply follows the synchronized level.

Clearing a sticky flag takes a handshake. Software must read the flag as 1, and its next write must then carry a 0 in that bit. A write of 0 without that earlier read leaves the flag alone, so a request that arrives between a poll and a clear is not lost. Hardware events alone set flags. A combined interrupt output ORs the seven request bits, each gated by its own enable, for use by a downstream controller.

Top module: `irq_flag_reg`

## Requirements
- R1: Synchronous active-high reset clears every flag, every read marker, the read-data register and the interrupt output to 0.
- R2: Bit 7 of the register always reads 0, and writes to it have no effect.
- R3: Bit 6 shows the timer request input, registered once. It is 1 one clock edge after `timer_req` is driven high, and bus writes never change it.
- R4: In edge mode (`pin_level_mode[n]`=0), a rising edge on synchronized pin n sets bit n (bits 5..0 map to pins 5..0). The bit is updated on the third clock edge after the pin changes, and it stays set after the pin returns low.
- R5: In edge mode, a write with 0 in bit n clears the flag only if a read has returned 1 in bit n since the last write. A write of 0 without such a read leaves the flag set.
- R6: Writing 1 to any bit never sets a flag.
- R7: Any write disarms the read markers of all bits. A write of 1 after a read, followed by a write of 0, leaves the flag set.
- R8: If a rising edge on the synchronized pin coincides with a clearing write, the flag stays set.
- R9: In level mode (`pin_level_mode[n]`=1), bit n equals the synchronized pin level with the same three-edge latency, and writes have no effect on it.
- R10: On the first clock edge at which a pin is in level mode after being in edge mode, its flag and marker are cleared. Level tracking resumes on the next edge.
- R11: When `pin_invert[n]`=1, the raw pin is inverted before synchronization, so a falling raw pin is what sets an edge-mode flag.
- R12: `irq_out` is registered. It equals the OR of register bits 6..0 ANDed with `irq_en[6:0]`, as they stood at the previous clock edge.
- R13: `bus_rdata` is loaded with the register value only on clock edges where `bus_rd` is high, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe; loads bus_rdata and arms read markers |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data; a 0 in an armed edge-mode bit clears it |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 6 | Raw external request pins |
| pin_invert | input | 6 | Per-pin polarity inversion |
| pin_level_mode | input | 6 | Per-pin detection mode: 0 edge, 1 level |
| timer_req | input | 1 | Internal timer interrupt request |
| irq_en | input | 7 | Per-bit enable for the combined interrupt |
| irq_out | output | 1 | Registered combined interrupt request |

## Verification
A pin change is due in its flag on the third clock edge after the pin is driven: two synchronizer stages, then the flag register. The bench therefore waits two edges and reads on the third, expecting the old value, and then reads again to see the new one. The timer bit is due one edge after `timer_req`, and `irq_out` one edge after the flag that feeds it. A write clears a flag on its own edge. All stimulus is driven, and all results sampled, one nanosecond after a rising edge. The coincidence case is timed so that the clearing write lands exactly on the third edge after a new pin rise.

// File: rtl/irqf_pkg.sv
package irqf_pkg;

  localparam int unsigned IRQF_PINS_DEF = 6;
  localparam int unsigned IRQF_SYNC_DEF = 2;

  typedef enum logic {
    DET_EDGE  = 1'b0,
    DET_LEVEL = 1'b1
  } irqf_det_e;

endpackage

// File: rtl/irqf_sync.sv
module irqf_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/irqf_pin_flag.sv
module irqf_pin_flag
  import irqf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sync_i,
  input  logic level_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o,
  output logic marker_o,
  output logic rise_o
);

  logic      prev_q;
  irqf_det_e mode_q;
  irqf_det_e mode_w;
  logic      switch_w;
  logic      clear_w;

  assign mode_w   = level_i ? DET_LEVEL : DET_EDGE;
  assign switch_w = (mode_w == DET_LEVEL) && (mode_q == DET_EDGE);
  assign rise_o   = sync_i & ~prev_q;
  // A clearing write loses to a coincident edge.
  assign clear_w  = wr_i & ~wbit_i & marker_o & ~rise_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q   <= 1'b0;
      mode_q   <= DET_EDGE;
      flag_o   <= 1'b0;
      marker_o <= 1'b0;
    end else begin
      prev_q <= sync_i;
      mode_q <= mode_w;
      if (switch_w) begin
        flag_o   <= 1'b0;
        marker_o <= 1'b0;
      end else if (mode_w == DET_LEVEL) begin
        flag_o   <= sync_i;
        marker_o <= 1'b0;
      end else begin
        if (rise_o)       flag_o <= 1'b1;
        else if (clear_w) flag_o <= 1'b0;
        if (wr_i)                marker_o <= 1'b0;
        else if (rd_i && flag_o) marker_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
  import irqf_pkg::*;
#(
  parameter int unsigned NUM_PINS    = IRQF_PINS_DEF,
  parameter int unsigned SYNC_STAGES = IRQF_SYNC_DEF,
  localparam int unsigned REG_W      = NUM_PINS + 2,
  localparam int unsigned SRC_W      = NUM_PINS + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    bus_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] pin_invert,
  input  logic [NUM_PINS-1:0] pin_level_mode,
  input  logic                timer_req,
  input  logic [SRC_W-1:0]    irq_en,
  output logic                irq_out
);

  logic [NUM_PINS-1:0] raw_w;
  logic [NUM_PINS-1:0] sync_s;
  logic [NUM_PINS-1:0] flag_q;
  logic [NUM_PINS-1:0] marker_q;
  logic [NUM_PINS-1:0] rise_w;
  logic                timer_q;
  logic [REG_W-1:0]    status_w;
  logic                unused_wbits;

  assign raw_w        = pin_in ^ pin_invert;
  assign unused_wbits = ^bus_wdata[REG_W-1:NUM_PINS];

  irqf_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (raw_w),
    .sync_o  (sync_s)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    irqf_pin_flag u_flag (
      .clk      (clk),
      .rst      (rst),
      .sync_i   (sync_s[g]),
      .level_i  (pin_level_mode[g]),
      .rd_i     (bus_rd),
      .wr_i     (bus_wr),
      .wbit_i   (bus_wdata[g]),
      .flag_o   (flag_q[g]),
      .marker_o (marker_q[g]),
      .rise_o   (rise_w[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) timer_q <= 1'b0;
    else     timer_q <= timer_req;
  end

  assign status_w = {1'b0, timer_q, flag_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= status_w;
      irq_out <= |(status_w[SRC_W-1:0] & irq_en);
    end
  end

endmodule

// File: rtl/irqf_checker.sv
module irqf_checker #(
  parameter int unsigned NUM_PINS = 6,
  localparam int unsigned REG_W   = NUM_PINS + 2,
  localparam int unsigned SRC_W   = NUM_PINS + 1
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_rd,
  input logic                bus_wr,
  input logic [REG_W-1:0]    bus_wdata,
  input logic [REG_W-1:0]    bus_rdata,
  input logic                timer_req,
  input logic [SRC_W-1:0]    irq_en,
  input logic                irq_out,
  input logic [NUM_PINS-1:0] pin_level_mode,
  input logic [REG_W-1:0]    status,
  input logic [NUM_PINS-1:0] flags,
  input logic [NUM_PINS-1:0] marker,
  input logic [NUM_PINS-1:0] sync_s,
  input logic [NUM_PINS-1:0] rise
);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (bus_rdata == '0 && !irq_out && flags == '0 && marker == '0));

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    bus_rdata[REG_W-1] == 1'b0);

  a_r3_timer_mirror: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> status[NUM_PINS] == $past(timer_req));

  a_r12_irq_combine: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq_out == $past(|(status[SRC_W-1:0] & irq_en)));

  a_r13_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_rd)) |-> $stable(bus_rdata));

  a_r7_write_disarms: assert property (@(posedge clk) disable iff (rst)
    bus_wr |=> marker == '0);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    a_r5_clear_needs_arm: assert property (@(posedge clk) disable iff (rst)
      ($fell(flags[i]) && !$past(pin_level_mode[i]))
        |-> $past(bus_wr && !bus_wdata[i] && marker[i]));

    a_r6_set_needs_edge: assert property (@(posedge clk) disable iff (rst)
      ($rose(flags[i]) && !$past(pin_level_mode[i])) |-> $past(rise[i]));

    a_r8_edge_wins: assert property (@(posedge clk) disable iff (rst)
      (rise[i] && !pin_level_mode[i]) |=> flags[i]);

    a_r9_level_track: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2) && $past(pin_level_mode[i]) &&
       $past(pin_level_mode[i], 2)) |-> flags[i] == $past(sync_s[i]));
  end

endmodule

bind irq_flag_reg irqf_checker #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .bus_rd         (bus_rd),
  .bus_wr         (bus_wr),
  .bus_wdata      (bus_wdata),
  .bus_rdata      (bus_rdata),
  .timer_req      (timer_req),
  .irq_en         (irq_en),
  .irq_out        (irq_out),
  .pin_level_mode (pin_level_mode),
  .status         (status_w),
  .flags          (flag_q),
  .marker         (marker_q),
  .sync_s         (sync_s),
  .rise           (rise_w)
);

// File: tb/tb_irq_flag_reg.sv
`timescale 1ns/1ps
module tb_irq_flag_reg;

  localparam int LAT = 3;  // two sync stages plus the flag register

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [5:0] pin_in = '0;
  logic [5:0] pin_invert = '0;
  logic [5:0] pin_level_mode = '0;
  logic       timer_req = 1'b0;
  logic [6:0] irq_en = '0;
  logic       irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_flag_reg dut (
    .clk            (clk),
    .rst            (rst),
    .bus_rd         (bus_rd),
    .bus_wr         (bus_wr),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .pin_in         (pin_in),
    .pin_invert     (pin_invert),
    .pin_level_mode (pin_level_mode),
    .timer_req      (timer_req),
    .irq_en         (irq_en),
    .irq_out        (irq_out)
  );

  task automatic tick(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [5:0] pins, input logic [5:0] inv, input logic [5:0] lvl);
    rst = 1'b1; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    pin_in = pins; pin_invert = inv; pin_level_mode = lvl;
    timer_req = 1'b0; irq_en = '0;
    tick(2);
    rst = 1'b0;
  endtask

  task automatic rd_reg(output logic [7:0] d);
    bus_rd = 1'b1;
    tick();
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wr_reg(input logic [7:0] d);
    bus_wr = 1'b1; bus_wdata = d;
    tick();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset('0, '0, '0);
    check("R1 rdata after reset", bus_rdata, 8'h00);
    check("R1 irq_out after reset", {7'b0, irq_out}, 8'h00);
    rd_reg(d);
    check("R1 register after reset", d, 8'h00);
  endtask

  task automatic t_edge_sticky();
    logic [7:0] d;
    do_reset('0, '0, '0);
    pin_in[0] = 1'b1;
    tick(LAT - 1);
    rd_reg(d);
    check("R4 flag not before third edge", d, 8'h00);
    rd_reg(d);
    check("R4 flag set by edge", d, 8'h01);
    pin_in[0] = 1'b0;
    tick(LAT);
    rd_reg(d);
    check("R4 flag sticky after pin low", d, 8'h01);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    do_reset('0, '0, '0);
    pin_in[1] = 1'b1; tick(LAT); pin_in[1] = 1'b0;
    wr_reg(8'h00);
    rd_reg(d);
    check("R5 write 0 without read keeps flag", d, 8'h02);
    wr_reg(8'h00);
    rd_reg(d);
    check("R5 write 0 after read clears flag", d, 8'h00);
  endtask

  task automatic t_write_ones();
    logic [7:0] d;
    do_reset('0, '0, '0);
    wr_reg(8'hFF);
    rd_reg(d);
    check("R6 R2 write of ones sets nothing", d, 8'h00);
    pin_in[2] = 1'b1; tick(LAT); pin_in[2] = 1'b0;
    rd_reg(d);
    check("R4 pin2 flag set", d, 8'h04);
    wr_reg(8'hFF);
    wr_reg(8'h00);
    rd_reg(d);
    check("R7 marker disarmed by earlier write", d, 8'h04);
  endtask

  task automatic t_edge_wins();
    logic [7:0] d;
    do_reset('0, '0, '0);
    pin_in[5] = 1'b1; tick(LAT); pin_in[5] = 1'b0;
    rd_reg(d);
    check("R4 pin5 flag set", d, 8'h20);
    tick(LAT);
    pin_in[5] = 1'b1;
    tick(LAT - 1);
    wr_reg(8'h00);  // lands on the edge where the new rise is seen
    rd_reg(d);
    check("R8 coincident edge keeps flag", d, 8'h20);
    pin_in[5] = 1'b0;
  endtask

  task automatic t_level();
    logic [7:0] d;
    do_reset('0, '0, 6'b010000);
    pin_in[4] = 1'b1;
    tick(LAT);
    rd_reg(d);
    check("R9 level flag follows high pin", d, 8'h10);
    wr_reg(8'h00);
    rd_reg(d);
    check("R9 write 0 ignored in level mode", d, 8'h10);
    pin_in[4] = 1'b0;
    tick(LAT);
    wr_reg(8'h10);
    rd_reg(d);
    check("R9 level flag follows low pin, write 1 ignored", d, 8'h00);
  endtask

  task automatic t_switch();
    logic [7:0] d;
    do_reset('0, '0, '0);
    pin_in[3] = 1'b1;
    tick(LAT);
    pin_level_mode[3] = 1'b1;
    tick();
    rd_reg(d);
    check("R10 switch to level clears flag", d, 8'h00);
    rd_reg(d);
    check("R10 level tracking resumes", d, 8'h08);
  endtask

  task automatic t_invert();
    logic [7:0] d;
    do_reset(6'b001000, 6'b001000, '0);
    tick(LAT);
    rd_reg(d);
    check("R11 inverted high pin gives no request", d, 8'h00);
    pin_in[3] = 1'b0;
    tick(LAT);
    rd_reg(d);
    check("R11 falling raw pin sets inverted flag", d, 8'h08);
  endtask

  task automatic t_timer();
    logic [7:0] d;
    do_reset('0, '0, '0);
    timer_req = 1'b1;
    tick();
    rd_reg(d);
    check("R3 timer bit one edge after request", d, 8'h40);
    wr_reg(8'h00);
    rd_reg(d);
    check("R3 write does not clear timer bit", d, 8'h40);
    timer_req = 1'b0;
    tick();
    rd_reg(d);
    check("R3 timer bit follows request low", d, 8'h00);
  endtask

  task automatic t_irq();
    do_reset('0, '0, '0);
    pin_in[0] = 1'b1;
    tick(LAT + 1);
    check("R12 masked flag gives no irq", {7'b0, irq_out}, 8'h00);
    irq_en = 7'h01;
    tick();
    check("R12 enabled flag raises irq", {7'b0, irq_out}, 8'h01);
    irq_en = 7'h40;
    tick();
    check("R12 irq drops when enable removed", {7'b0, irq_out}, 8'h00);
    timer_req = 1'b1;
    tick();
    check("R12 irq not before timer bit registered", {7'b0, irq_out}, 8'h00);
    tick();
    check("R12 timer request raises irq", {7'b0, irq_out}, 8'h01);
    pin_in[0] = 1'b0;
  endtask

  task automatic t_hold();
    logic [7:0] d;
    do_reset('0, '0, '0);
    pin_in[0] = 1'b1; tick(LAT + 1); pin_in[0] = 1'b0;
    check("R13 rdata holds without read", bus_rdata, 8'h00);
    rd_reg(d);
    check("R13 read loads rdata", d, 8'h01);
    wr_reg(8'h00);
    tick();
    check("R13 rdata holds after clear", bus_rdata, 8'h01);
    rd_reg(d);
    check("R5 flag cleared by armed write", d, 8'h00);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_edge_sticky();
    t_clear();
    t_write_ones();
    t_edge_wins();
    t_level();
    t_switch();
    t_invert();
    t_timer();
    t_irq();
    t_hold();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule